// File: doc/BRIEF.md
# Match-Set Overflow-Clear PWM Channel

This block is one pulse-width modulator channel. A free-running up-counter steps once per clock and wraps from all-ones back to zero. The channel keeps a compare value. When the counter reaches that value, a set/reset latch drives the output high. When the counter has just wrapped to zero, the latch drives the output low. The compare value is therefore the number of low clocks in each period. The duty cycle is (2^CNT_W − value) / 2^CNT_W, which is (65536 − value)/65536 at the default width of 16 bits.

Software writes the compare value as a low half and a high half into a shadow register. The shadow is copied into the active compare register only on the last count of a period, so a period never mixes two values. Three configuration bits must all be set for the channel to run. These are compare enable, PWM mode and wide (full-width) mode. Each match sets a sticky event flag. With its enable bit set, the flag raises an interrupt request, so that software can write the next value in step with the waveform.

Top module: `pwm_msoc_top`

## Requirements
- R1: The counter resets to 0, increases by one on every clock and wraps from all-ones to 0, giving a period of 2^CNT_W clocks; its value is visible on `count_out`.
- R2: Writing `cmp_wr_lo` loads the lower CNT_W−BYTE_W bits of the shadow and writing `cmp_wr_hi` loads the upper BYTE_W bits. The active compare value takes the shadow only in the clock where the counter is all-ones, so a value written mid-period takes effect from the next count of 0.
- R3: While running, the output goes high the clock after the counter equals the active compare value and goes low the clock after the counter is 0, so each period has exactly as many low clocks as the compare value.
- R4: When counter-is-zero and match fall in the same clock (compare value 0), the set wins and the output stays high for the whole period.
- R5: The channel runs only when `cfg_cmp_en`, `cfg_pwm_mode` and `cfg_wide_mode` are all 1; otherwise the output is low one clock later and matches set no flag.
- R6: A match while running sets `match_flag` the next clock; the flag stays set until `flag_clr` is applied, and a match in the same clock as `flag_clr` leaves the flag set.
- R7: `irq` is high exactly when `match_flag` is high and `cfg_irq_en` is 1.
- R8: Reset clears the counter, the shadow and active compare values, the output and the flag.
- R9: While running, the flag is set exactly once per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cmp_en | input | 1 | Compare enable bit |
| cfg_pwm_mode | input | 1 | PWM mode bit |
| cfg_wide_mode | input | 1 | Full-width mode bit |
| cfg_irq_en | input | 1 | Match interrupt enable |
| cmp_wr_lo | input | 1 | Write strobe for the lower part of the shadow compare |
| cmp_wr_hi | input | 1 | Write strobe for the upper part of the shadow compare |
| cmp_wr_byte | input | BYTE_W | Data for either compare write |
| flag_clr | input | 1 | Clears the match flag |
| count_out | output | CNT_W | Current counter value |
| pwm_out | output | 1 | PWM waveform |
| match_flag | output | 1 | Sticky match event flag |
| irq | output | 1 | Match interrupt request |

## Verification
`count_out` is the counter register itself. `pwm_out` and `match_flag` lag the counter value that caused them by one clock. A shadow write reaches the comparator at the count of 0 after the next all-ones count. The bench drives and samples on the falling edge. It measures each period over the window from count 1 up to and including the next count 0, so a waveform set or cleared by counts 0 through all-ones of one period lands entirely inside that window. Timing checks such as set-beats-clear place the stimulus on the falling edge just before the counter value that matches, and read the result one falling edge later.

// File: rtl/pwm_msoc_pkg.sv
`timescale 1ns/1ps
package pwm_msoc_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_SET   = 2'd1,
        ACT_CLEAR = 2'd2,
        ACT_OFF   = 2'd3
    } latch_act_e;

    // Priority: disabled channel forces low, then match sets, then wrap clears.
    function automatic latch_act_e pick_action(input logic running,
                                               input logic hit,
                                               input logic wrapped);
        latch_act_e act;
        if (!running)     act = ACT_OFF;
        else if (hit)     act = ACT_SET;
        else if (wrapped) act = ACT_CLEAR;
        else              act = ACT_HOLD;
        return act;
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count_q,
    output logic             at_zero,
    output logic             at_top
);
    localparam logic [CNT_W-1:0] TOP_VAL = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tbase_state_t;

    tbase_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.cnt = state_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign count_q = state_q.cnt;
    assign at_zero = (state_q.cnt == '0);
    assign at_top  = (state_q.cnt == TOP_VAL);

    // R1: one step per clock, wrapping naturally at all-ones
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> state_q.cnt == CNT_W'($past(state_q.cnt) + 1'b1));

endmodule

// File: rtl/pwm_cmp_bank.sv
`timescale 1ns/1ps
module pwm_cmp_bank #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = (CNT_W + 1) / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              load,
    output logic [CNT_W-1:0]  active_q
);
    localparam int LO_W = CNT_W - BYTE_W;

    typedef struct packed {
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] active;
    } cmp_state_t;

    cmp_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_lo) state_d.shadow[LO_W-1:0]     = wr_byte[LO_W-1:0];
        if (wr_hi) state_d.shadow[CNT_W-1:LO_W] = wr_byte;
        // Transfer uses the shadow as it stood before any same-cycle write.
        if (load)  state_d.active = state_q.shadow;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign active_q = state_q.active;

    // R2: active compare only changes on the last count of a period
    assert_active_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> state_q.active == $past(state_q.active));
    // R2: on that count it takes the shadow contents
    assert_active_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> state_q.active == $past(state_q.shadow));

endmodule

// File: rtl/pwm_out_latch.sv
`timescale 1ns/1ps
module pwm_out_latch
    import pwm_msoc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic running,
    input  logic hit,
    input  logic wrapped,
    input  logic flag_clr,
    output logic pwm_q,
    output logic flag_q
);
    typedef struct packed {
        logic pwm;
        logic flag;
    } latch_state_t;

    latch_state_t state_d, state_q;
    latch_act_e   act;

    always_comb begin
        state_d = state_q;
        act     = pick_action(running, hit, wrapped);
        unique case (act)
            ACT_OFF:   state_d.pwm = 1'b0;
            ACT_SET:   state_d.pwm = 1'b1;
            ACT_CLEAR: state_d.pwm = 1'b0;
            default:   state_d.pwm = state_q.pwm;
        endcase
        if (running && hit)  state_d.flag = 1'b1;
        else if (flag_clr)   state_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign pwm_q  = state_q.pwm;
    assign flag_q = state_q.flag;

    // R3 / R4: a match while running sets output and flag, even on a wrap
    assert_match_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && hit) |=> (pwm_q && flag_q));
    // R3: wrap without match clears the output
    assert_wrap_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && wrapped && !hit) |=> !pwm_q);
    // R5: stopped channel drives low
    assert_stopped_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> !pwm_q);
    // R6: flag is sticky without a clear
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);
    // R6: flag never rises without a running match
    assert_flag_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !(running && hit)) |=> !flag_q);

endmodule

// File: rtl/pwm_msoc_top.sv
`timescale 1ns/1ps
module pwm_msoc_top #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = (CNT_W + 1) / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cmp_en,
    input  logic              cfg_pwm_mode,
    input  logic              cfg_wide_mode,
    input  logic              cfg_irq_en,
    input  logic              cmp_wr_lo,
    input  logic              cmp_wr_hi,
    input  logic [BYTE_W-1:0] cmp_wr_byte,
    input  logic              flag_clr,
    output logic [CNT_W-1:0]  count_out,
    output logic              pwm_out,
    output logic              match_flag,
    output logic              irq
);
    logic [CNT_W-1:0] count_w;
    logic [CNT_W-1:0] active_w;
    logic             at_zero_w;
    logic             at_top_w;
    logic             running_w;
    logic             hit_w;

    assign running_w = cfg_cmp_en & cfg_pwm_mode & cfg_wide_mode;
    assign hit_w     = (count_w == active_w);

    pwm_timebase #(.CNT_W(CNT_W)) u_tbase (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_q (count_w),
        .at_zero (at_zero_w),
        .at_top  (at_top_w)
    );

    pwm_cmp_bank #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lo    (cmp_wr_lo),
        .wr_hi    (cmp_wr_hi),
        .wr_byte  (cmp_wr_byte),
        .load     (at_top_w),
        .active_q (active_w)
    );

    pwm_out_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .running  (running_w),
        .hit      (hit_w),
        .wrapped  (at_zero_w),
        .flag_clr (flag_clr),
        .pwm_q    (pwm_out),
        .flag_q   (match_flag)
    );

    assign count_out = count_w;
    assign irq       = match_flag & cfg_irq_en;

    // R4: compare value zero while running keeps the output high into the next clock
    assert_full_duty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running_w && active_w == '0 && pwm_out && $stable(active_w)) |=> pwm_out);

endmodule

// File: tb/pwm_msoc_top_tb_top.sv
`timescale 1ns/1ps
module pwm_msoc_top_tb_top;
    localparam int CW  = 8;
    localparam int BW  = 4;
    localparam int PER = 1 << CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_cmp_en = 1'b0, cfg_pwm_mode = 1'b0, cfg_wide_mode = 1'b0, cfg_irq_en = 1'b0;
    logic          cmp_wr_lo = 1'b0, cmp_wr_hi = 1'b0, flag_clr = 1'b0;
    logic [BW-1:0] cmp_wr_byte = '0;
    logic [CW-1:0] count_out;
    logic          pwm_out, match_flag, irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pwm_msoc_top #(.CNT_W(CW), .BYTE_W(BW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_cmp_en(cfg_cmp_en), .cfg_pwm_mode(cfg_pwm_mode),
        .cfg_wide_mode(cfg_wide_mode), .cfg_irq_en(cfg_irq_en),
        .cmp_wr_lo(cmp_wr_lo), .cmp_wr_hi(cmp_wr_hi), .cmp_wr_byte(cmp_wr_byte),
        .flag_clr(flag_clr), .count_out(count_out), .pwm_out(pwm_out),
        .match_flag(match_flag), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cmp(input int v);
        @(negedge clk); cmp_wr_lo = 1'b1; cmp_wr_byte = BW'(v);
        @(negedge clk); cmp_wr_lo = 1'b0; cmp_wr_hi = 1'b1; cmp_wr_byte = BW'(v >> BW);
        @(negedge clk); cmp_wr_hi = 1'b0;
    endtask

    task automatic wait_count(input int v);
        do @(negedge clk); while (count_out != CW'(v));
    endtask

    // Window: counts 1 .. PER-1 then the next 0. Flag cleared whenever seen.
    task automatic measure(output int lows, output int flags, output int irq_bad);
        lows = 0; flags = 0; irq_bad = 0;
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            if (!pwm_out) lows++;
            if (match_flag) begin
                flags++;
                if (irq !== cfg_irq_en) irq_bad++;
                flag_clr = 1'b1;
            end else begin
                if (irq !== 1'b0) irq_bad++;
                flag_clr = 1'b0;
            end
        end
        flag_clr = 1'b0;
    endtask

    task automatic run_period(input int c, output int lows, output int flags, output int irq_bad);
        write_cmp(c);
        wait_count(0);
        flag_clr = 1'b1;
        measure(lows, flags, irq_bad);
    endtask

    initial begin
        int lows, flags, ibad, c0;
        int sweep [12] = '{0, 1, 2, 7, 16, 63, 100, 128, 129, 200, 254, 255};

        cfg_irq_en = 1'b1; cfg_cmp_en = 1'b1; cfg_pwm_mode = 1'b1; cfg_wide_mode = 1'b1;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 count in reset", int'(count_out), 0);
        chk("R8 pwm in reset", int'(pwm_out), 0);
        chk("R8 flag in reset", int'(match_flag), 0);
        chk("R7 irq in reset", int'(irq), 0);
        rst_n = 1'b1;

        // R1: stepping and wrap
        @(negedge clk);
        c0 = int'(count_out);
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            chk("R1 step", int'(count_out), (c0 + k) % PER);
        end
        wait_count(PER - 1);
        @(negedge clk);
        chk("R1 wrap", int'(count_out), 0);

        // R3 / R4 / R7 / R9: low-clock sweep
        foreach (sweep[j]) begin
            cfg_irq_en = j[0];
            run_period(sweep[j], lows, flags, ibad);
            chk($sformatf("R3 low clocks c=%0d", sweep[j]), lows, sweep[j]);
            chk($sformatf("R9 flags per period c=%0d", sweep[j]), flags, 1);
            chk($sformatf("R7 irq gating c=%0d", sweep[j]), ibad, 0);
            if (sweep[j] == 0) chk("R4 full duty", lows, 0);
        end
        cfg_irq_en = 1'b1;

        // R2: mid-period write waits for the wrap
        run_period(50, lows, flags, ibad);
        wait_count(0);
        wait_count(10);
        write_cmp(20);
        wait_count(30);
        chk("R2 old compare kept in current period", int'(pwm_out), 0);
        wait_count(0);
        flag_clr = 1'b1;
        measure(lows, flags, ibad);
        chk("R2 new compare next period", lows, 20);

        // R6: sticky flag, clear, set beats clear (active compare is 20)
        wait_count(25);
        chk("R6 flag set after match", int'(match_flag), 1);
        repeat (100) @(negedge clk);
        chk("R6 flag sticky", int'(match_flag), 1);
        wait_count(5);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R6 flag cleared", int'(match_flag), 0);
        wait_count(20);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R6 set beats clear", int'(match_flag), 1);
        @(negedge clk);
        chk("R6 flag held after", int'(match_flag), 1);

        // R5: each mode bit off stops the channel
        for (int b = 0; b < 3; b++) begin
            cfg_cmp_en    = (b != 0);
            cfg_pwm_mode  = (b != 1);
            cfg_wide_mode = (b != 2);
            run_period(60, lows, flags, ibad);
            chk($sformatf("R5 low while bit %0d off", b), lows, PER);
            chk($sformatf("R5 no flag while bit %0d off", b), flags, 0);
        end
        cfg_cmp_en = 1'b1; cfg_pwm_mode = 1'b1; cfg_wide_mode = 1'b1;

        // R8: mid-run reset clears compare registers
        run_period(90, lows, flags, ibad);
        chk("R3 low clocks before reset", lows, 90);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R8 pwm after reset", int'(pwm_out), 0);
        chk("R8 count after reset", int'(count_out), 0);
        rst_n = 1'b1;
        wait_count(0);
        flag_clr = 1'b1;
        measure(lows, flags, ibad);
        chk("R8 compare zero after reset", lows, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule